// File: doc/BRIEF.md
# Byte-serial storage logical AND engine

This block performs a bitwise logical AND between two fields in byte-addressed storage, or between one storage byte and an immediate byte. It writes the result over the first operand. A single start handshake supplies the operation: the mode, the destination (first operand) address, the source (second operand) address, a length code and an immediate byte. The engine then works one byte at a time through a request/ready memory port that has a single outstanding transaction.

The processing order follows the architectural rules for overlapping fields. Each result byte reaches storage before the next pair of operand bytes is fetched. Overlapping source and destination fields therefore behave exactly as a strict byte-by-byte walk. When the whole field has been written, the engine raises a one-cycle done pulse together with a two-bit condition code. The condition code tells whether any result bit was set.

Memory protocol: `mem_req_o` is held, with address, write enable and write data stable, until `mem_ready_i` is seen high on a rising clock edge. Read data on `mem_rdata_i` is taken in the cycle where `mem_ready_i` is high.

Top module: `bytewise_and_engine`

## Requirements
- R1: Each stored result byte is the bitwise AND of the current destination byte and the operand byte. Each result bit is 1 only where both input bits are 1. The result is written back to the destination address.
- R2: In storage mode (`imm_mode_i`=0), the engine processes `len_i`+1 bytes, so a code of 0 gives 1 byte and a code of 255 gives 256 bytes. Both fields are walked from the lowest address upward.
- R3: When the source and destination fields overlap, the final storage contents equal those of a byte-by-byte walk in which each result byte is stored before the next bytes are read.
- R4: In immediate mode (`imm_mode_i`=1), exactly one destination byte is read, ANDed with `imm_i` and written back. No other address is accessed, and `src_addr_i` and `len_i` are ignored.
- R5: Each storage-mode byte uses three transactions in this order: read the source, read the destination, write the destination. Only one request is outstanding at a time. A pending request keeps its address, write enable and write data unchanged until it is accepted.
- R6: `cc_o` is 0 when every result bit of the whole field is zero and 1 otherwise. Bit 1 of `cc_o` is always 0, so codes 2 and 3 never occur.
- R7: `done_o` is high for exactly one cycle, the cycle after the final store is accepted, and `cc_o` is valid in that cycle. With zero-wait memory, done is seen 3·(`len_i`+1) clock edges after the start edge in storage mode, and 2 edges after it in immediate mode.
- R8: A start is accepted only while `busy_o` is low. `busy_o` is high from the cycle after acceptance through the done cycle. A start raised while busy has no effect on storage or on the transaction sequence.
- R9: While in reset and after it, `busy_o`, `mem_req_o`, `done_o` and `cc_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when idle |
| imm_mode_i | input | 1 | 1 = immediate mode, 0 = storage-to-storage mode |
| dst_addr_i | input | ADDR_W | First operand (destination) start address |
| src_addr_i | input | ADDR_W | Second operand start address |
| len_i | input | 8 | Byte count minus one (storage mode) |
| imm_i | input | 8 | Immediate operand byte |
| busy_o | output | 1 | Operation in progress |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Request accepted this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| cc_o | output | 2 | Condition code: 0 = all-zero result, 1 = nonzero |

## Verification
With zero-wait memory, every byte costs one edge per transaction. The done pulse is therefore due 3·n edges after the accepting edge in storage mode and 2 edges after it in immediate mode. The bench counts rising edges from the start edge and compares the count with these figures. It samples `done_o`, `busy_o` and `cc_o` at the falling edge, where the final store's effect is already visible, and checks one falling edge later that the pulse has ended. With wait states the timing varies, so storage contents and the logged transaction sequence are compared only after done. The expected values come from a byte-by-byte model held in the bench.

// File: rtl/andeng_pkg.sv
package andeng_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 8;
  localparam int CC_W   = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SRC,
    ST_RD_DST,
    ST_WR_DST,
    ST_DONE
  } andeng_state_e;
endpackage

// File: rtl/andeng_ctrl.sv
module andeng_ctrl
  import andeng_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          imm_mode_i,
  input  logic          mem_ready_i,
  input  logic          last_i,
  output andeng_state_e state_o,
  output logic          launch_o,
  output logic          cap_src_o,
  output logic          cap_dst_o,
  output logic          store_ok_o,
  output logic          step_o
);
  andeng_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    launch_o   = 1'b0;
    cap_src_o  = 1'b0;
    cap_dst_o  = 1'b0;
    store_ok_o = 1'b0;
    step_o     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        launch_o = 1'b1;
        state_d  = imm_mode_i ? ST_RD_DST : ST_RD_SRC;
      end
      ST_RD_SRC: if (mem_ready_i) begin
        cap_src_o = 1'b1;
        state_d   = ST_RD_DST;
      end
      ST_RD_DST: if (mem_ready_i) begin
        cap_dst_o = 1'b1;
        state_d   = ST_WR_DST;
      end
      ST_WR_DST: if (mem_ready_i) begin
        store_ok_o = 1'b1;
        if (last_i) state_d = ST_DONE;
        else begin
          step_o  = 1'b1;
          state_d = ST_RD_SRC;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/andeng_ptr.sv
module andeng_ptr
  import andeng_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              imm_mode_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] dst_ptr_o,
  output logic [ADDR_W-1:0] src_ptr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);

  logic [ADDR_W-1:0] dst_q, src_q;
  logic [LEN_W-1:0]  rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q <= '0;
      src_q <= '0;
      rem_q <= '0;
    end else if (launch_i) begin
      dst_q <= dst_addr_i;
      src_q <= src_addr_i;
      rem_q <= imm_mode_i ? '0 : len_i;
    end else if (step_i) begin
      dst_q <= dst_q + ADDR_ONE;
      src_q <= src_q + ADDR_ONE;
      rem_q <= rem_q - LEN_ONE;
    end
  end

  assign dst_ptr_o = dst_q;
  assign src_ptr_o = src_q;
  assign last_o    = (rem_q == '0);
endmodule

// File: rtl/andeng_data.sv
module andeng_data
  import andeng_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              imm_mode_i,
  input  logic [BYTE_W-1:0] imm_i,
  input  logic              cap_src_i,
  input  logic              cap_dst_i,
  input  logic              store_ok_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              nz_o
);
  logic [BYTE_W-1:0] opnd_q, res_q;
  logic              nz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opnd_q <= '0;
      res_q  <= '0;
      nz_q   <= 1'b0;
    end else begin
      if (launch_i && imm_mode_i) opnd_q <= imm_i;
      else if (cap_src_i)         opnd_q <= rdata_i;
      if (cap_dst_i) res_q <= rdata_i & opnd_q;
      // sticky over the field, cleared per operation
      if (launch_i)        nz_q <= 1'b0;
      else if (store_ok_i) nz_q <= nz_q | (|res_q);
    end
  end

  assign wdata_o = res_q;
  assign nz_o    = nz_q;
endmodule

// File: rtl/bytewise_and_engine.sv
module bytewise_and_engine
  import andeng_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              imm_mode_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [7:0]        len_i,
  input  logic [7:0]        imm_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              done_o,
  output logic [1:0]        cc_o
);
  andeng_state_e     state;
  logic              launch, cap_src, cap_dst, store_ok, step, last, nz;
  logic [ADDR_W-1:0] dst_ptr, src_ptr;

  andeng_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .imm_mode_i (imm_mode_i),
    .mem_ready_i(mem_ready_i),
    .last_i     (last),
    .state_o    (state),
    .launch_o   (launch),
    .cap_src_o  (cap_src),
    .cap_dst_o  (cap_dst),
    .store_ok_o (store_ok),
    .step_o     (step)
  );

  andeng_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch),
    .imm_mode_i (imm_mode_i),
    .step_i     (step),
    .dst_addr_i (dst_addr_i),
    .src_addr_i (src_addr_i),
    .len_i      (len_i),
    .dst_ptr_o  (dst_ptr),
    .src_ptr_o  (src_ptr),
    .last_o     (last)
  );

  andeng_data u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch),
    .imm_mode_i (imm_mode_i),
    .imm_i      (imm_i),
    .cap_src_i  (cap_src),
    .cap_dst_i  (cap_dst),
    .store_ok_i (store_ok),
    .rdata_i    (mem_rdata_i),
    .wdata_o    (mem_wdata_o),
    .nz_o       (nz)
  );

  assign busy_o     = (state != ST_IDLE);
  assign mem_req_o  = (state == ST_RD_SRC) || (state == ST_RD_DST) || (state == ST_WR_DST);
  assign mem_we_o   = (state == ST_WR_DST);
  assign mem_addr_o = (state == ST_RD_SRC) ? src_ptr : dst_ptr;
  assign done_o     = (state == ST_DONE);
  assign cc_o       = {1'b0, nz};
endmodule

// File: rtl/andeng_chk.sv
module andeng_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [7:0]        mem_wdata_o,
  input logic              mem_ready_i,
  input logic              done_o,
  input logic [1:0]        cc_o
);
  AST_CC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cc_o[1]); // R6

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_DONE_AFTER_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_req_o && mem_we_o && mem_ready_i)); // R7

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o))); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !done_o)); // R8

  AST_DONE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_o && !mem_req_o)); // R8
endmodule

bind bytewise_and_engine andeng_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_ready_i(mem_ready_i),
  .done_o     (done_o),
  .cc_o       (cc_o)
);

// File: tb/tb_bytewise_and_engine.sv
module tb_bytewise_and_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 12;
  localparam int MEMN = 1 << AW;
  localparam int LOGN = 1024;

  typedef struct packed {
    logic          imm;
    logic [AW-1:0] dst;
    logic [AW-1:0] src;
    logic [7:0]    len;
    logic [7:0]    immb;
    logic [7:0]    sd_d;
    logic [7:0]    sd_s;
    logic [3:0]    lat;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h100, 12'h200, 8'd0,   8'h00, 8'd3, 8'd5, 4'd0}, // R1 single byte
    '{1'b0, 12'h110, 12'h210, 8'd7,   8'h00, 8'd4, 8'd6, 4'd1}, // R2 multi byte, waits
    '{1'b0, 12'h300, 12'h301, 8'd5,   8'h00, 8'd7, 8'd7, 4'd0}, // R3 src ahead
    '{1'b0, 12'h401, 12'h400, 8'd5,   8'h00, 8'd9, 8'd8, 4'd2}, // R3 dst ahead
    '{1'b0, 12'h500, 12'h500, 8'd3,   8'h00, 8'd2, 8'd2, 4'd0}, // R3 same field
    '{1'b1, 12'h600, 12'h000, 8'd9,   8'h5A, 8'd1, 8'd1, 4'd1}, // R4 immediate
    '{1'b1, 12'h610, 12'h000, 8'd0,   8'h00, 8'd5, 8'd1, 4'd0}, // R6 imm zero
    '{1'b0, 12'h700, 12'h780, 8'd15,  8'h00, 8'd6, 8'd0, 4'd0}, // R6 zero field
    '{1'b0, 12'h800, 12'hA00, 8'd255, 8'h00, 8'd8, 8'd9, 4'd0}  // R2 max length
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, imm_mode = 1'b0;
  logic [AW-1:0] dst_a = '0, src_a = '0;
  logic [7:0] len = '0, immb = '0;
  logic busy, req, we, done, ready;
  logic [AW-1:0] addr;
  logic [7:0] wdata, rdata;
  logic [1:0] cc;

  logic [7:0]    mem [MEMN];
  logic [7:0]    exp_mem [MEMN];
  logic [AW-1:0] log_addr [LOGN];
  logic          log_we [LOGN];
  int            log_n = 0;
  int            wcnt = 0;
  int            cur_lat = 0;
  logic          pl_we = 1'b0, log_clr = 1'b0;
  logic [AW-1:0] pl_addr = '0;
  logic [7:0]    pl_data = '0;

  int n_run = 0, n_fail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bytewise_and_engine #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .imm_mode_i(imm_mode),
    .dst_addr_i(dst_a), .src_addr_i(src_a), .len_i(len), .imm_i(immb),
    .busy_o(busy), .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_ready_i(ready),
    .done_o(done), .cc_o(cc)
  );

  assign ready = req && (wcnt >= cur_lat);
  assign rdata = mem[addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pl_we) mem[pl_addr] <= pl_data;
    if (log_clr) log_n <= 0;
    else if (req && ready) begin
      if (log_n < LOGN) begin
        log_addr[log_n] <= addr;
        log_we[log_n]   <= we;
      end
      log_n <= log_n + 1;
      if (we) mem[addr] <= wdata;
    end
    if (!req || ready) wcnt <= 0;
    else               wcnt <= wcnt + 1;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int sd);
    int v;
    v = (a * 37 + sd * 91) ^ (a >> 2) ^ (sd << 3);
    return (sd == 0) ? 8'h00 : 8'(v);
  endfunction

  task automatic preload(input logic [AW-1:0] base, input int n, input int sd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pl_we   = 1'b1;
      pl_addr = AW'(base + AW'(i));
      pl_data = pat(int'(pl_addr), sd);
    end
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  // Byte-serial reference; returns expected cc bit.
  function automatic int ref_op(input logic im, input logic [AW-1:0] d,
                                input logic [AW-1:0] s, input int n,
                                input logic [7:0] ib);
    int nz = 0;
    logic [AW-1:0] da, sa;
    logic [7:0] r;
    for (int a = 0; a < MEMN; a++) exp_mem[a] = mem[a];
    for (int i = 0; i < n; i++) begin
      da = AW'(d + AW'(i));
      sa = AW'(s + AW'(i));
      r  = exp_mem[da] & (im ? ib : exp_mem[sa]);
      exp_mem[da] = r;
      if (r != 0) nz = 1;
    end
    return nz;
  endfunction

  // Issues one op; returns edges from acceptance to done (-1 on timeout).
  task automatic issue(input logic im, input logic [AW-1:0] d,
                       input logic [AW-1:0] s, input logic [7:0] l,
                       input logic [7:0] ib, input int lat,
                       input bit poke, output int edges, output logic [1:0] cc_s);
    @(negedge clk);
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0;
    cur_lat = lat;
    imm_mode = im; dst_a = d; src_a = s; len = l; immb = ib; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
    edges = 0;
    cc_s = 2'b00;
    while (!done && edges < 5000) begin
      if (poke && edges == 4) begin
        // start while busy with a different op: must be ignored
        imm_mode = 1'b1; dst_a = 12'hD00; immb = 8'h00; start = 1'b1;
      end else start = 1'b0;
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
    start = 1'b0;
    if (!done) edges = -1;
    else begin
      cc_s = cc;
      chk(busy == 1'b1, "R8", "busy in done cycle", int'(busy), 1);
      @(negedge clk);
      chk(done == 1'b0, "R7", "done single cycle", int'(done), 0);
      chk(busy == 1'b0, "R8", "idle after done", int'(busy), 0);
    end
  endtask

  task automatic verify(input logic im, input logic [AW-1:0] d,
                        input logic [AW-1:0] s, input int n, input int exp_cc,
                        input logic [1:0] cc_s, input string tag);
    int bad = 0, first = -1, exp_tx, k, bad_ord;
    for (int a = 0; a < MEMN; a++)
      if (mem[a] !== exp_mem[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    chk(bad == 0, tag, "storage mismatches (first addr in actual)", first, -1);
    chk(int'(cc_s) == exp_cc, "R6", "cc at done", int'(cc_s), exp_cc);
    exp_tx = im ? 2 : 3 * n;
    chk(log_n == exp_tx, im ? "R4" : "R2", "transaction count", log_n, exp_tx);
    bad_ord = 0;
    k = 0;
    for (int i = 0; i < n && k + 2 < LOGN && k < log_n; i++) begin
      if (!im) begin
        if (log_we[k] !== 1'b0 || log_addr[k] !== AW'(s + AW'(i))) bad_ord++;
        k++;
      end
      if (log_we[k] !== 1'b0 || log_addr[k] !== AW'(d + AW'(i))) bad_ord++;
      k++;
      if (log_we[k] !== 1'b1 || log_addr[k] !== AW'(d + AW'(i))) bad_ord++;
      k++;
    end
    chk(bad_ord == 0, "R5", "transaction order errors", bad_ord, 0);
  endtask

  initial begin : watchdog
    wait (cyc > 190000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int edges, n, ecc;
    logic [1:0] cs;
    #(3 * CLK_PERIOD + 1);
    // R9 reset state
    chk(busy == 0 && req == 0 && done == 0 && cc == 0, "R9", "outputs in reset",
        int'({busy, req, done, cc}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && req == 0 && done == 0 && cc == 0, "R9", "outputs after reset",
        int'({busy, req, done, cc}), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      n = VECS[v].imm ? 1 : int'(VECS[v].len) + 1;
      preload(VECS[v].dst, n, int'(VECS[v].sd_d));
      if (!VECS[v].imm) preload(VECS[v].src, n, int'(VECS[v].sd_s));
      ecc = ref_op(VECS[v].imm, VECS[v].dst, VECS[v].src, n, VECS[v].immb);
      issue(VECS[v].imm, VECS[v].dst, VECS[v].src, VECS[v].len, VECS[v].immb,
            int'(VECS[v].lat), 1'b0, edges, cs);
      chk(edges >= 0, "R7", "done seen", edges, 0);
      verify(VECS[v].imm, VECS[v].dst, VECS[v].src, n, ecc, cs,
             VECS[v].dst == VECS[v].src || VECS[v].dst == VECS[v].src + 1 ||
             VECS[v].src == VECS[v].dst + 1 ? "R3" : "R1");
    end

    // R7 latency, storage mode, 3 bytes, zero-wait
    preload(12'h900, 3, 11);
    preload(12'h980, 3, 12);
    ecc = ref_op(1'b0, 12'h900, 12'h980, 3, 8'h00);
    issue(1'b0, 12'h900, 12'h980, 8'd2, 8'h00, 0, 1'b0, edges, cs);
    chk(edges == 9, "R7", "edges to done, storage mode", edges, 9);
    verify(1'b0, 12'h900, 12'h980, 3, ecc, cs, "R1");

    // R7 latency, immediate mode, zero-wait
    preload(12'h9F0, 1, 13);
    ecc = ref_op(1'b1, 12'h9F0, 12'h000, 1, 8'hF0);
    issue(1'b1, 12'h9F0, 12'h000, 8'd0, 8'hF0, 0, 1'b0, edges, cs);
    chk(edges == 2, "R7", "edges to done, immediate mode", edges, 2);
    verify(1'b1, 12'h9F0, 12'h000, 1, ecc, cs, "R4");

    // R8 start while busy is ignored
    preload(12'hB00, 4, 14);
    preload(12'hC00, 4, 15);
    preload(12'hD00, 1, 16);
    ecc = ref_op(1'b0, 12'hB00, 12'hC00, 4, 8'h00);
    issue(1'b0, 12'hB00, 12'hC00, 8'd3, 8'h00, 2, 1'b1, edges, cs);
    chk(mem[12'hD00] == pat(12'hD00, 16), "R8", "byte targeted by ignored start",
        int'(mem[12'hD00]), int'(pat(12'hD00, 16)));
    verify(1'b0, 12'hB00, 12'hC00, 4, ecc, cs, "R8");
    repeat (3) @(negedge clk);
    chk(busy == 0 && req == 0, "R8", "no op launched by ignored start",
        int'({busy, req}), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule